// File: doc/BRIEF.md
# Dual-Modulus Main Divider Chain

This block is a cycle-level model of the feedback divider in a fractional-N frequency synthesizer. It runs on the oscillator input clock, so each clock cycle stands for one input cycle. It produces one single-cycle divided pulse per output period. A prescaler stage counts each of its own output cycles as either 10 or 11 input cycles. A main counter counts M+1 of those prescaler cycles. A swallow counter decides how many of them use the long modulus of 11.

An external noise-shaping modulator adds a small signed offset to the swallow count. The block samples that offset once per output period, which lets the average divide ratio take fractional values. The block clamps the effective swallow count to its legal range and records a sticky flag when it has to do so. A bypass mode removes the prescaler: the input is then divided by M+1 alone, and the swallow count and the offset are ignored.

Top module: `fnd_main_div`

## Requirements
- R1: While reset is high, and in the first cycle after it, div_pulse, mod_sel and sat_err are all 0.
- R2: After reset is released, the first div_pulse is high in the cycle after the Nth rising edge that follows the first rising edge with reset low. N is the divide ratio of the configuration present at that first edge.
- R3: With bypass low and a zero offset, the distance between successive div_pulse assertions is N = 10*(M+1) + A input cycles, for 1 <= M <= 511 and A <= M+1.
- R4: In each period, mod_sel is high for the first A_eff prescaler cycles, which is 11*A_eff input cycles, starting in the cycle where div_pulse is high. It is low for the rest of the period.
- R5: div_pulse is high for exactly one cycle per period.
- R6: m_ratio, a_ratio, dsm_off and bypass are sampled only at the rising edge that raises div_pulse. Changing them in the middle of a period does not change that period.
- R7: dsm_off is a 4-bit two's-complement value. With bypass low, the effective swallow count is A_eff = A + dsm_off, and the period is 10*(M+1) + A_eff.
- R8: With bypass high, the period is M+1 cycles, mod_sel stays 0, and a_ratio and dsm_off have no effect on the period or on sat_err.
- R9: If A + dsm_off is below 0, A_eff becomes 0. If it is above M+1, A_eff becomes M+1. In either case sat_err is set.
- R10: Once set, sat_err stays high until reset, even when later configurations are legal.
- R11: An m_ratio of 0 is treated as 1, in both normal and bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator input clock, one edge per input cycle |
| rst | input | 1 | Synchronous active-high reset |
| m_ratio | input | 9 | Main counter setting M |
| a_ratio | input | 4 | Swallow count A |
| dsm_off | input | 4 | Signed per-period offset from the modulator |
| bypass | input | 1 | High: divide by M+1 without the prescaler |
| div_pulse | output | 1 | Single-cycle divided output pulse |
| mod_sel | output | 1 | High while the prescaler uses modulus 11 |
| sat_err | output | 1 | Sticky flag: swallow count was clamped |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that the inputs are stable at each edge. Because M is at least 1 after the zero substitution, every period lasts at least two cycles, and the single-cycle pulse property relies on this. The bench changes inputs only on falling edges. To check timing, it waits for the period that starts after a change before measuring, except in the hold scenario, where a change is made on purpose part-way through a period. The offsets used span both the second-order and the third-order modulator ranges, and both clamp directions are exercised after a fresh reset.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
    localparam int unsigned FND_M_W    = 9;
    localparam int unsigned FND_A_W    = 4;
    localparam int unsigned FND_OFF_W  = 4;
    localparam int unsigned FND_PRE_LO = 10;
endpackage

// File: rtl/fnd_cfg.sv
// Resolves the per-period configuration: M clamp, effective swallow count, saturation.
module fnd_cfg #(
    parameter int unsigned M_W   = fnd_pkg::FND_M_W,
    parameter int unsigned A_W   = fnd_pkg::FND_A_W,
    parameter int unsigned OFF_W = fnd_pkg::FND_OFF_W
) (
    input  logic [M_W-1:0]          m_in,
    input  logic [A_W-1:0]          a_in,
    input  logic signed [OFF_W-1:0] off_in,
    input  logic                    byp_in,
    output logic [M_W-1:0]          m_eff,
    output logic [M_W:0]            a_eff,
    output logic                    sat
);
    localparam int unsigned S_W = M_W + 2;

    logic signed [S_W-1:0] sum_s;
    logic signed [S_W-1:0] lim_s;

    always_comb begin
        // R11: zero M is replaced by the minimum legal value
        m_eff = (m_in == '0) ? M_W'(1) : m_in;
        lim_s = $signed({2'b00, m_eff}) + $signed(S_W'(1));
        sum_s = $signed({{(S_W-A_W){1'b0}}, a_in});
        if (!byp_in) begin
            sum_s = sum_s + $signed({{(S_W-OFF_W){off_in[OFF_W-1]}}, off_in});
        end
        sat   = 1'b0;
        a_eff = sum_s[M_W:0];
        if (byp_in) begin
            a_eff = '0;
        end else if (sum_s < 0) begin
            a_eff = '0;
            sat   = 1'b1;
        end else if (sum_s > lim_s) begin
            a_eff = lim_s[M_W:0];
            sat   = 1'b1;
        end
    end
endmodule

// File: rtl/fnd_presc.sv
// Prescaler model: counts input cycles of one prescaler output cycle.
module fnd_presc #(
    parameter int unsigned PRE_LO = fnd_pkg::FND_PRE_LO,
    localparam int unsigned P_W   = $clog2(PRE_LO + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [P_W-1:0] len_in,
    output logic           tc
);
    typedef struct packed {
        logic [P_W-1:0] cnt;
    } presc_t;

    presc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tc   = (st_q.cnt == '0);
        if (tc) begin
            st_d.cnt = len_in;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fnd_mctr.sv
// Main and swallow counters, period boundary, pulse and sticky flag.
module fnd_mctr #(
    parameter int unsigned M_W    = fnd_pkg::FND_M_W,
    parameter int unsigned PRE_LO = fnd_pkg::FND_PRE_LO,
    localparam int unsigned P_W   = $clog2(PRE_LO + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tc,
    input  logic [M_W-1:0] m_eff,
    input  logic [M_W:0]   a_eff,
    input  logic           sat,
    input  logic           byp_in,
    output logic [P_W-1:0] len_out,
    output logic           pulse,
    output logic           mod_sel,
    output logic           err,
    output logic           byp_st,
    output logic           start_st
);
    typedef struct packed {
        logic           start;
        logic           byp;
        logic [M_W-1:0] m_cnt;
        logic [M_W:0]   a_cnt;
        logic           pulse;
        logic           err;
    } mctr_t;

    mctr_t        st_d, st_q;
    logic [M_W:0] a_nx;
    logic         bound;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        a_nx       = st_q.a_cnt;
        bound      = st_q.start || (tc && (st_q.m_cnt == '0));
        if (bound) begin
            // R6: configuration captured only here
            st_d.start = 1'b0;
            st_d.pulse = !st_q.start;
            st_d.byp   = byp_in;
            st_d.m_cnt = m_eff;
            a_nx       = byp_in ? '0 : a_eff;
            st_d.err   = st_q.err | sat;
        end else if (tc) begin
            st_d.m_cnt = st_q.m_cnt - 1'b1;
            a_nx       = (st_q.a_cnt != '0) ? (st_q.a_cnt - 1'b1) : '0;
        end
        st_d.a_cnt = a_nx;
        if (st_d.byp) begin
            len_out = '0;
        end else if (a_nx != '0) begin
            len_out = P_W'(PRE_LO);
        end else begin
            len_out = P_W'(PRE_LO - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.start <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse    = st_q.pulse;
    assign mod_sel  = (st_q.a_cnt != '0);
    assign err      = st_q.err;
    assign byp_st   = st_q.byp;
    assign start_st = st_q.start;
endmodule

// File: rtl/fnd_main_div.sv
module fnd_main_div #(
    parameter int unsigned M_W    = fnd_pkg::FND_M_W,
    parameter int unsigned A_W    = fnd_pkg::FND_A_W,
    parameter int unsigned OFF_W  = fnd_pkg::FND_OFF_W,
    parameter int unsigned PRE_LO = fnd_pkg::FND_PRE_LO
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [M_W-1:0]          m_ratio,
    input  logic [A_W-1:0]          a_ratio,
    input  logic signed [OFF_W-1:0] dsm_off,
    input  logic                    bypass,
    output logic                    div_pulse,
    output logic                    mod_sel,
    output logic                    sat_err
);
    localparam int unsigned P_W = $clog2(PRE_LO + 1);

    logic [M_W-1:0] m_eff;
    logic [M_W:0]   a_eff;
    logic           sat;
    logic           pre_tc;
    logic [P_W-1:0] pre_len;
    logic           byp_st;
    logic           start_st;

    fnd_cfg #(.M_W(M_W), .A_W(A_W), .OFF_W(OFF_W)) u_cfg (
        .m_in   (m_ratio),
        .a_in   (a_ratio),
        .off_in (dsm_off),
        .byp_in (bypass),
        .m_eff  (m_eff),
        .a_eff  (a_eff),
        .sat    (sat)
    );

    fnd_presc #(.PRE_LO(PRE_LO)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .len_in (pre_len),
        .tc     (pre_tc)
    );

    fnd_mctr #(.M_W(M_W), .PRE_LO(PRE_LO)) u_mctr (
        .clk      (clk),
        .rst      (rst),
        .tc       (pre_tc),
        .m_eff    (m_eff),
        .a_eff    (a_eff),
        .sat      (sat),
        .byp_in   (bypass),
        .len_out  (pre_len),
        .pulse    (div_pulse),
        .mod_sel  (mod_sel),
        .err      (sat_err),
        .byp_st   (byp_st),
        .start_st (start_st)
    );
endmodule

// File: rtl/fnd_main_div_chk.sv
module fnd_main_div_chk (
    input logic clk,
    input logic rst,
    input logic div_pulse,
    input logic mod_sel,
    input logic sat_err,
    input logic byp_st,
    input logic pre_tc,
    input logic start_st
);
    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sat_err |=> sat_err);

    // R8
    byp_no_msel_chk: assert property (@(posedge clk) disable iff (rst)
        byp_st |-> !mod_sel);

    // R4
    msel_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_sel) |-> (div_pulse || $past(start_st)));

    // R4
    msel_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_sel) |-> $past(pre_tc));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!div_pulse && !mod_sel && !sat_err));
endmodule

bind fnd_main_div fnd_main_div_chk i_fnd_main_div_chk (
    .clk       (clk),
    .rst       (rst),
    .div_pulse (div_pulse),
    .mod_sel   (mod_sel),
    .sat_err   (sat_err),
    .byp_st    (byp_st),
    .pre_tc    (pre_tc),
    .start_st  (start_st)
);

// File: tb/test_fnd_main_div.sv
`timescale 1ns/1ps
module test_fnd_main_div;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [8:0]        m_ratio = 9'd3;
    logic [3:0]        a_ratio = 4'd2;
    logic signed [3:0] dsm_off = 4'sd0;
    logic              bypass  = 1'b0;
    logic              div_pulse, mod_sel, sat_err;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fnd_main_div i_fnd_main_div (
        .clk(clk), .rst(rst), .m_ratio(m_ratio), .a_ratio(a_ratio),
        .dsm_off(dsm_off), .bypass(bypass),
        .div_pulse(div_pulse), .mod_sel(mod_sel), .sat_err(sat_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int m, input int a, input int off, input bit byp);
        m_ratio = 9'(m);
        a_ratio = 4'(a);
        dsm_off = 4'(off);
        bypass  = byp;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!div_pulse);
    endtask

    // Waits for the period that uses the current inputs, then measures it.
    task automatic measure(output int per, output int ms);
        wait_pulse();
        per = 0;
        ms  = mod_sel ? 1 : 0;
        @(negedge clk);
        per++;
        check(!div_pulse, "R5 pulse width", div_pulse, 0);
        if (!div_pulse) ms += mod_sel;
        while (!div_pulse) begin
            @(negedge clk);
            per++;
            if (!div_pulse) ms += mod_sel;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(!div_pulse && !mod_sel && !sat_err, "R1 reset outputs",
              {div_pulse, mod_sel, sat_err}, 0);
        rst = 1'b0;
    endtask

    task automatic t_reset_first();
        int n = 0;
        set_cfg(3, 2, 0, 1'b0);
        do_reset();
        do begin @(negedge clk); n++; end while (!div_pulse && n < 1000);
        check(n == 43, "R2 first pulse", n, 43);
    endtask

    task automatic run_int(input int m, input int a);
        int per, ms;
        set_cfg(m, a, 0, 1'b0);
        measure(per, ms);
        check(per == 10*(m+1)+a, "R3 integer period", per, 10*(m+1)+a);
        check(ms == 11*a, "R4 mod_sel cycles", ms, 11*a);
    endtask

    task automatic t_integer();
        run_int(1, 0);
        run_int(3, 2);
        run_int(9, 9);
        run_int(20, 15);
        run_int(511, 7);
    endtask

    task automatic run_frac(input int m, input int a, input int off);
        int per, ms;
        set_cfg(m, a, off, 1'b0);
        measure(per, ms);
        check(per == 10*(m+1)+a+off, "R7 fractional period", per, 10*(m+1)+a+off);
        check(ms == 11*(a+off), "R4 R7 mod_sel cycles", ms, 11*(a+off));
    endtask

    task automatic t_frac();
        run_frac(9, 3, 2);
        run_frac(9, 3, -1);
        run_frac(9, 3, -3);
        run_frac(9, 3, 4);
        check(!sat_err, "R7 no saturation in range", sat_err, 0);
    endtask

    task automatic t_hold();
        int n = 0;
        int per, ms;
        set_cfg(9, 3, 2, 1'b0);
        wait_pulse();
        wait_pulse();
        repeat (5) begin @(negedge clk); n++; end
        set_cfg(9, 3, -1, 1'b0);
        do begin @(negedge clk); n++; end while (!div_pulse);
        check(n == 105, "R6 mid-period change ignored", n, 105);
        per = 0;
        ms  = mod_sel ? 1 : 0;
        do begin
            @(negedge clk);
            per++;
            if (!div_pulse) ms += mod_sel;
        end while (!div_pulse);
        check(per == 102, "R6 new value next period", per, 102);
    endtask

    task automatic t_bypass();
        int per, ms;
        set_cfg(7, 15, 4, 1'b1);
        measure(per, ms);
        check(per == 8, "R8 bypass period", per, 8);
        check(ms == 0, "R8 bypass mod_sel", ms, 0);
        check(!sat_err, "R8 bypass no error", sat_err, 0);
        set_cfg(1, 9, -3, 1'b1);
        measure(per, ms);
        check(per == 2, "R8 bypass minimum", per, 2);
    endtask

    task automatic t_mzero();
        int per, ms;
        set_cfg(0, 1, 0, 1'b0);
        measure(per, ms);
        check(per == 21, "R11 zero M normal", per, 21);
        set_cfg(0, 0, 0, 1'b1);
        measure(per, ms);
        check(per == 2, "R11 zero M bypass", per, 2);
        check(!sat_err, "R11 no error", sat_err, 0);
    endtask

    task automatic t_sat();
        int per, ms;
        set_cfg(2, 0, -2, 1'b0);
        do_reset();
        measure(per, ms);
        check(per == 30, "R9 low clamp period", per, 30);
        check(sat_err, "R9 low clamp flag", sat_err, 1);
        set_cfg(1, 15, 0, 1'b0);
        do_reset();
        measure(per, ms);
        check(per == 22, "R9 high clamp period", per, 22);
        check(ms == 22, "R9 high clamp mod_sel", ms, 22);
        check(sat_err, "R9 high clamp flag", sat_err, 1);
        set_cfg(1, 0, 0, 1'b0);
        measure(per, ms);
        check(per == 20, "R10 legal period after clamp", per, 20);
        check(sat_err, "R10 flag held", sat_err, 1);
        do_reset();
        check(!sat_err, "R10 cleared by reset", sat_err, 0);
    endtask

    initial begin
        t_reset_first();
        t_integer();
        t_frac();
        t_hold();
        t_bypass();
        t_mzero();
        t_sat();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule